// File: doc/BRIEF.md
# Execution Unit Pair Availability Estimator

This block watches a pair of identical execution units that share one rename-register mapper and each own an issue queue. Every cycle it samples status lines (mapper full, per-queue full, per-unit busy, per-unit result produced, and the two possible reasons a completion stalled). From these it keeps saturating counters over a sampling window of programmable length.

When a window closes, every counter is copied into a readable snapshot and cleared in that same cycle. The pair is then classified as high or low usage. It is high when the fraction of stalled cycles is above a programmed stall threshold, or when the observed result count, taken as a fraction of the most results the pair could have produced in the window, is above a programmed event threshold. Both fractions are compared in units of 1/256 by cross-multiplying, so no divider is needed. A stall threshold of zero makes any stalled cycle sufficient on its own.

A thread scheduler reads the one-cycle classification pulse and the usage flag to pair a low-usage thread with a high-usage one. Snapshots and settings are reached through a small address/data register port.

Top module: `fu_avail_est`

## Requirements
- R1: Counter 0 (read address 4) counts the cycles in which `map_full` is 1.
- R2: Counters 1 and 2 (addresses 5 and 6) count the cycles in which `iq_full[0]` and `iq_full[1]` are 1, respectively.
- R3: Counters 3 to 6 (addresses 7 to 10) count cycles with unit 0 busy and unit 1 idle, unit 1 busy and unit 0 idle, both idle, and at least one busy, respectively.
- R4: Counters 7 and 8 (addresses 11 and 12) count the cycles in which `unit_result[0]` and `unit_result[1]` are 1. Counter 10 (address 14) is the event total: it grows by the number of result bits set in a cycle (0, 1 or 2).
- R5: Counter 9 (address 13) counts the cycles in which the mapper or either issue queue is full.
- R6: The window length is the value at address 0; a value of 0 acts as 1. A window covers that many consecutive sampled cycles, starting with the first cycle after reset. The snapshots include the window's last cycle. The live counters restart from zero for the next window. `class_valid` is 1 for exactly one cycle: the cycle after the window's last sampled cycle.
- R7: A counter that reaches 2^CNT_W-1 stays there until its window closes; it does not wrap.
- R8: With window length W, snapshot stall count S, snapshot event total E, stall threshold TS (address 1), event threshold TE (address 2) and maximum rate per cycle RM (address 3), `usage_high` is 1 exactly when S*256 > TS*W or E*256 > TE*RM*W. It changes only together with `class_valid`.
- R9: `last_stall_cause` holds the most recent completion-stall reason: 2 if `stall_cache` was 1 in that cycle (even with `stall_unit` also 1), 1 if only `stall_unit` was 1. A cycle with neither input leaves it unchanged.
- R10: Addresses 0 to 3 read back their written values. Addresses 4 to 14 are snapshots, and writes to them have no effect. Address 15 reads {`usage_high`, `last_stall_cause`} in bits 2 to 0.
- R11: After reset, `class_valid`, `usage_high`, `last_stall_cause` and all snapshots are 0. The window length, stall threshold, event threshold and maximum rate take the parameter reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_full | input | 1 | Shared rename mapper has no free entry this cycle |
| iq_full | input | 2 | Per-unit issue queue full this cycle |
| unit_busy | input | 2 | Per-unit busy this cycle |
| unit_result | input | 2 | Per-unit result produced this cycle |
| stall_cache | input | 1 | Completion stalled by a cache miss this cycle |
| stall_unit | input | 1 | Completion stalled by an execution unit this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | WIN_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, combinational from `reg_addr` |
| usage_high | output | 1 | Classification of the last closed window |
| class_valid | output | 1 | One-cycle pulse marking a new classification |
| last_stall_cause | output | 2 | Most recent completion-stall reason |

## Verification
Status inputs driven before a rising edge are counted at that edge. The snapshot, `usage_high` and the `class_valid` pulse from a window are all visible in the cycle after the window's last counted edge. `last_stall_cause` and register writes take effect one edge after they are driven. The bench drives and samples at falling edges. It synchronises to a `class_valid` pulse, drives the next window's first sample in that same slot, and feeds exactly W samples. It then checks at the falling edge right after the W-th rising edge, reading snapshots combinationally before any further edge. It also confirms that the pulse has dropped one falling edge into the next window.

// File: rtl/fu_avail_pkg.sv
package fu_avail_pkg;

   localparam int NCNT = 11;

   // counter slots (their order fixes the snapshot address map)
   localparam int C_MAPFULL = 0;
   localparam int C_IQ0FULL = 1;
   localparam int C_IQ1FULL = 2;
   localparam int C_U0ONLY  = 3;
   localparam int C_U1ONLY  = 4;
   localparam int C_IDLE    = 5;
   localparam int C_ANYBUSY = 6;
   localparam int C_DONE0   = 7;
   localparam int C_DONE1   = 8;
   localparam int C_STALL   = 9;
   localparam int C_EVENTS  = 10;

   // register addresses
   localparam int A_WIN   = 0;
   localparam int A_STHR  = 1;
   localparam int A_ETHR  = 2;
   localparam int A_RATE  = 3;
   localparam int A_SNAP0 = 4;
   localparam int A_STAT  = A_SNAP0 + NCNT;

   // ratios are expressed in 1/256 units
   localparam int FRAC_SH = 8;

   typedef enum logic [1:0] {
      CAUSE_NONE  = 2'd0,
      CAUSE_UNIT  = 2'd1,
      CAUSE_CACHE = 2'd2
   } stall_cause_e;

endpackage

// File: rtl/avail_sat_counter.sv
module avail_sat_counter #(
   parameter int CNT_W = 16,
   parameter int INC_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [INC_W-1:0] inc,
   input  logic             win_end,
   output logic [CNT_W-1:0] snap
);

   localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

   if (INC_W > CNT_W) begin : g_bad_inc
      $error("avail_sat_counter: INC_W must not exceed CNT_W");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W:0]   sum;
   logic [CNT_W-1:0] nxt;

   always_comb begin
      sum = {1'b0, cnt} + (CNT_W+1)'(inc);
      nxt = sum[CNT_W] ? MAXV : sum[CNT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         snap <= '0;
      end else if (win_end) begin
         cnt  <= '0;
         snap <= nxt;
      end else begin
         cnt  <= nxt;
      end
   end

   // R7: inside a window the count never moves backwards
   assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> cnt >= $past(cnt));

   // R7: a full counter stays full until its window closes
   assert_hold_max_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAXV && !win_end) |=> cnt == MAXV);

   // R6: a closing window restarts the live count
   assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> cnt == '0);

   // R10: the readable copy changes only at a window boundary
   assert_snap_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(snap));

endmodule

// File: rtl/avail_window_timer.sv
module avail_window_timer #(
   parameter int WIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIN_W-1:0] win_len,
   output logic [WIN_W-1:0] win_eff,
   output logic             win_end
);

   logic [WIN_W-1:0] cyc;
   logic [WIN_W:0]   cyc_p1;

   always_comb begin
      win_eff = (win_len == '0) ? WIN_W'(1) : win_len;
      cyc_p1  = {1'b0, cyc} + (WIN_W+1)'(1);
      win_end = cyc_p1 >= {1'b0, win_eff};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cyc <= '0;
      else if (win_end) cyc <= '0;
      else              cyc <= cyc + WIN_W'(1);
   end

   // R6: the cycle index always starts over after a boundary
   assert_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
      win_end |=> cyc == '0);

endmodule

// File: rtl/avail_usage_classifier.sv
module avail_usage_classifier
   import fu_avail_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int WIN_W  = 16,
   parameter int THR_W  = 8,
   parameter int RATE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              win_end,
   input  logic [WIN_W-1:0]  win_eff,
   input  logic [THR_W-1:0]  stall_thr,
   input  logic [THR_W-1:0]  evt_thr,
   input  logic [RATE_W-1:0] max_rate,
   input  logic [CNT_W-1:0]  stall_snap,
   input  logic [CNT_W-1:0]  evt_snap,
   output logic              usage_high,
   output logic              class_valid
);

   localparam int LHS_W = CNT_W + FRAC_SH;
   localparam int RHS_W = THR_W + RATE_W + WIN_W;
   localparam int CMP_W = ((LHS_W > RHS_W) ? LHS_W : RHS_W) + 1;

   logic [WIN_W-1:0]  l_win;
   logic [THR_W-1:0]  l_sthr, l_ethr;
   logic [RATE_W-1:0] l_rate;
   logic [CMP_W-1:0]  stall_lhs, stall_rhs, evt_lhs, evt_rhs;

   // settings are frozen with the snapshots so the verdict matches its window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         class_valid <= 1'b0;
         l_win       <= '0;
         l_sthr      <= '0;
         l_ethr      <= '0;
         l_rate      <= '0;
      end else begin
         class_valid <= win_end;
         if (win_end) begin
            l_win  <= win_eff;
            l_sthr <= stall_thr;
            l_ethr <= evt_thr;
            l_rate <= max_rate;
         end
      end
   end

   always_comb begin
      stall_lhs  = CMP_W'(stall_snap) << FRAC_SH;
      evt_lhs    = CMP_W'(evt_snap) << FRAC_SH;
      stall_rhs  = CMP_W'(l_sthr) * CMP_W'(l_win);
      evt_rhs    = CMP_W'(l_ethr) * CMP_W'(l_rate) * CMP_W'(l_win);
      usage_high = (stall_lhs > stall_rhs) || (evt_lhs > evt_rhs);
   end

   // R8: the verdict moves only together with the valid pulse
   assert_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !class_valid |-> $stable(usage_high));

   // R8: a window with neither stalls nor results is never high usage
   assert_quiet_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stall_snap == '0 && evt_snap == '0) |-> !usage_high);

endmodule

// File: rtl/fu_avail_est.sv
module fu_avail_est
   import fu_avail_pkg::*;
#(
   parameter int CNT_W           = 16,
   parameter int WIN_W           = 16,
   parameter int THR_W           = 8,
   parameter int RATE_W          = 2,
   parameter int DATA_W          = 16,
   parameter int ADDR_W          = 4,
   parameter int WIN_RESET       = 1000,
   parameter int STALL_THR_RESET = 0,
   parameter int EVT_THR_RESET   = 128,
   parameter int RATE_RESET      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              map_full,
   input  logic [1:0]        iq_full,
   input  logic [1:0]        unit_busy,
   input  logic [1:0]        unit_result,
   input  logic              stall_cache,
   input  logic              stall_unit,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [WIN_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              usage_high,
   output logic              class_valid,
   output logic [1:0]        last_stall_cause
);

   // elaboration-time parameter checks
   if (WIN_W < THR_W || WIN_W < RATE_W) begin : g_bad_wdata
      $error("fu_avail_est: write data (WIN_W) narrower than a setting field");
   end
   if (DATA_W < CNT_W || DATA_W < WIN_W || DATA_W < 3) begin : g_bad_rdata
      $error("fu_avail_est: DATA_W too narrow for readout");
   end
   if (A_STAT >= (1 << ADDR_W)) begin : g_bad_addr
      $error("fu_avail_est: ADDR_W too small for the register map");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("fu_avail_est: CNT_W must be at least 2");
   end

   // settings
   logic [WIN_W-1:0]  win_len;
   logic [THR_W-1:0]  stall_thr, evt_thr;
   logic [RATE_W-1:0] max_rate;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_len   <= WIN_W'(WIN_RESET);
         stall_thr <= THR_W'(STALL_THR_RESET);
         evt_thr   <= THR_W'(EVT_THR_RESET);
         max_rate  <= RATE_W'(RATE_RESET);
      end else if (reg_wr) begin
         case (reg_addr)
            ADDR_W'(A_WIN):  win_len   <= reg_wdata;
            ADDR_W'(A_STHR): stall_thr <= reg_wdata[THR_W-1:0];
            ADDR_W'(A_ETHR): evt_thr   <= reg_wdata[THR_W-1:0];
            ADDR_W'(A_RATE): max_rate  <= reg_wdata[RATE_W-1:0];
            default: ;
         endcase
      end
   end

   // window timing
   logic             win_end;
   logic [WIN_W-1:0] win_eff;

   avail_window_timer #(.WIN_W(WIN_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .win_len (win_len),
      .win_eff (win_eff),
      .win_end (win_end)
   );

   // per-cycle increments for each counter slot
   logic [1:0] inc [NCNT];

   always_comb begin
      inc[C_MAPFULL] = {1'b0, map_full};
      inc[C_IQ0FULL] = {1'b0, iq_full[0]};
      inc[C_IQ1FULL] = {1'b0, iq_full[1]};
      inc[C_U0ONLY]  = {1'b0, unit_busy[0] & ~unit_busy[1]};
      inc[C_U1ONLY]  = {1'b0, unit_busy[1] & ~unit_busy[0]};
      inc[C_IDLE]    = {1'b0, ~(unit_busy[0] | unit_busy[1])};
      inc[C_ANYBUSY] = {1'b0, unit_busy[0] | unit_busy[1]};
      inc[C_DONE0]   = {1'b0, unit_result[0]};
      inc[C_DONE1]   = {1'b0, unit_result[1]};
      inc[C_STALL]   = {1'b0, map_full | iq_full[0] | iq_full[1]};
      inc[C_EVENTS]  = {1'b0, unit_result[0]} + {1'b0, unit_result[1]};
   end

   logic [CNT_W-1:0] snap [NCNT];

   for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      avail_sat_counter #(.CNT_W(CNT_W), .INC_W(2)) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .inc     (inc[k]),
         .win_end (win_end),
         .snap    (snap[k])
      );
   end

   avail_usage_classifier #(
      .CNT_W  (CNT_W),
      .WIN_W  (WIN_W),
      .THR_W  (THR_W),
      .RATE_W (RATE_W)
   ) u_class (
      .clk         (clk),
      .rst_n       (rst_n),
      .win_end     (win_end),
      .win_eff     (win_eff),
      .stall_thr   (stall_thr),
      .evt_thr     (evt_thr),
      .max_rate    (max_rate),
      .stall_snap  (snap[C_STALL]),
      .evt_snap    (snap[C_EVENTS]),
      .usage_high  (usage_high),
      .class_valid (class_valid)
   );

   // last completion-stall reason, cache miss first
   stall_cause_e cause_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cause_q <= CAUSE_NONE;
      else if (stall_cache) cause_q <= CAUSE_CACHE;
      else if (stall_unit)  cause_q <= CAUSE_UNIT;
   end

   assign last_stall_cause = cause_q;

   // R9: a cache-miss stall always wins the recorded reason
   assert_cache_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
      stall_cache |=> last_stall_cause == CAUSE_CACHE);

   // R9: with no stall reason present the recorded one is kept
   assert_cause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stall_cache && !stall_unit) |=> $stable(last_stall_cause));

   // readout
   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_W'(A_WIN):  reg_rdata = DATA_W'(win_len);
         ADDR_W'(A_STHR): reg_rdata = DATA_W'(stall_thr);
         ADDR_W'(A_ETHR): reg_rdata = DATA_W'(evt_thr);
         ADDR_W'(A_RATE): reg_rdata = DATA_W'(max_rate);
         ADDR_W'(A_STAT): reg_rdata = DATA_W'({usage_high, last_stall_cause});
         default: begin
            for (int k = 0; k < NCNT; k++) begin
               if (reg_addr == ADDR_W'(A_SNAP0 + k)) reg_rdata = DATA_W'(snap[k]);
            end
         end
      endcase
   end

endmodule

// File: tb/test_fu_avail_est.sv
`timescale 1ns/1ps
module test_fu_avail_est;

   localparam int CW = 8;
   localparam int WW = 10;
   localparam int AW = 4;
   localparam int DW = 16;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          map_full = 1'b0;
   logic [1:0]    iq_full = '0, unit_busy = '0, unit_result = '0;
   logic          stall_cache = 1'b0, stall_unit = 1'b0;
   logic          reg_wr = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [WW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic          usage_high, class_valid;
   logic [1:0]    last_stall_cause;

   always #2 clk = ~clk;

   fu_avail_est #(
      .CNT_W(8), .WIN_W(10), .THR_W(8), .RATE_W(2), .DATA_W(16), .ADDR_W(4),
      .WIN_RESET(16), .STALL_THR_RESET(0), .EVT_THR_RESET(128), .RATE_RESET(2)
   ) i_fu_avail_est (
      .clk(clk), .rst_n(rst_n), .map_full(map_full), .iq_full(iq_full),
      .unit_busy(unit_busy), .unit_result(unit_result),
      .stall_cache(stall_cache), .stall_unit(stall_unit),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .usage_high(usage_high), .class_valid(class_valid),
      .last_stall_cause(last_stall_cause)
   );

   int  n_chk = 0;
   int  n_fail = 0;
   int  exp_cause = 0;
   bit  done = 0;
   string tags [11] = '{"R1","R2","R2","R3","R3","R3","R3","R4","R4","R5","R4"};

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic rd(input int a, output int v);
      reg_addr = AW'(a);
      #0.1;
      v = int'(reg_rdata);
   endtask

   function automatic int sat(input int x);
      return (x > CMAX) ? CMAX : x;
   endfunction

   task automatic drive(input bit mf, q0, q1, b0, b1, d0, d1, sc, su);
      map_full    = mf;
      iq_full     = {q1, q0};
      unit_busy   = {b1, b0};
      unit_result = {d1, d0};
      stall_cache = sc;
      stall_unit  = su;
      if (sc)      exp_cause = 2;
      else if (su) exp_cause = 1;
   endtask

   task automatic gen(input int p, input int i,
                      output bit mf, q0, q1, b0, b1, d0, d1, sc, su);
      if (p == 99) begin
         {mf, q0, q1, b0, b1, d0, d1, sc, su} = '1;
      end else begin
         mf = ((i + p) % 5 == 0) && (p % 2 == 0);
         q0 = (p % 4 != 3) && (i % 3 == p % 3);
         q1 = (p % 4 != 3) && ((i * p) % 4 == 1);
         b0 = ((i * 3 + p) % 4 < 2);
         b1 = ((i + 2 * p) % 3 == 0);
         d0 = b0 && (i % 2 == 0);
         d1 = b1;
         sc = (i % 5 == p % 5);
         su = (i % 3 == 0);
      end
   endtask

   // entered at a falling edge on a window boundary; leaves at the next one
   task automatic run_window(input int p, input int w, input int st, input int et, input int rt);
      int e [11];
      int weff, v, hi;
      bit mf, q0, q1, b0, b1, d0, d1, sc, su;
      weff = (w == 0) ? 1 : w;
      for (int k = 0; k < 11; k++) e[k] = 0;
      for (int i = 0; i < weff; i++) begin
         if (i > 0) @(negedge clk);
         if (i == 1) chk("R6", "valid drops after one cycle", int'(class_valid), 0);
         gen(p, i, mf, q0, q1, b0, b1, d0, d1, sc, su);
         drive(mf, q0, q1, b0, b1, d0, d1, sc, su);
         e[0]  += int'(mf);
         e[1]  += int'(q0);
         e[2]  += int'(q1);
         e[3]  += int'(b0 && !b1);
         e[4]  += int'(b1 && !b0);
         e[5]  += int'(!b0 && !b1);
         e[6]  += int'(b0 || b1);
         e[7]  += int'(d0);
         e[8]  += int'(d1);
         e[9]  += int'(mf || q0 || q1);
         e[10] += int'(d0) + int'(d1);
      end
      @(negedge clk);
      chk("R6", "valid at window close", int'(class_valid), 1);
      for (int k = 0; k < 11; k++) begin
         rd(4 + k, v);
         chk(tags[k], $sformatf("snapshot %0d pattern %0d", k, p), v, sat(e[k]));
      end
      if (p == 99) begin
         rd(4 + 6, v);
         chk("R7", "busy counter saturated", v, CMAX);
         rd(4 + 10, v);
         chk("R7", "event total saturated", v, CMAX);
      end
      hi = ((sat(e[9]) * 256 > st * weff) || (sat(e[10]) * 256 > et * rt * weff)) ? 1 : 0;
      chk("R8", $sformatf("usage flag pattern %0d", p), int'(usage_high), hi);
      chk("R9", "last stall cause", int'(last_stall_cause), exp_cause);
      rd(15, v);
      chk("R10", "status register", v, hi * 4 + exp_cause);
   endtask

   // entered at a falling edge on a window boundary; leaves at a later boundary
   task automatic set_cfg(input int w, input int st, input int et, input int rt, input bit ro_test);
      int v0, v1, v;
      drive(0, 0, 0, 0, 0, 0, 0, 0, 0);
      v0 = 0;
      if (ro_test) rd(4, v0);
      reg_wr = 1'b1;
      reg_addr = AW'(1); reg_wdata = WW'(st);
      @(negedge clk); reg_addr = AW'(2); reg_wdata = WW'(et);
      @(negedge clk); reg_addr = AW'(3); reg_wdata = WW'(rt);
      @(negedge clk); reg_addr = AW'(4); reg_wdata = WW'('h55);
      @(negedge clk); reg_addr = AW'(0); reg_wdata = WW'(w);
      @(negedge clk); reg_wr = 1'b0;
      if (ro_test) begin
         rd(4, v1);
         chk("R10", "write to snapshot ignored", v1, v0);
      end
      while (!class_valid) @(negedge clk);
      rd(0, v); chk("R10", "window length readback", v, w);
      rd(1, v); chk("R10", "stall threshold readback", v, st);
      rd(2, v); chk("R10", "event threshold readback", v, et);
      rd(3, v); chk("R10", "max rate readback", v, rt);
   endtask

   initial begin
      int v, n;
      repeat (3) @(negedge clk);
      chk("R11", "valid in reset", int'(class_valid), 0);
      chk("R11", "usage in reset", int'(usage_high), 0);
      chk("R11", "cause in reset", int'(last_stall_cause), 0);
      rd(0, v);  chk("R11", "window length reset", v, 16);
      rd(1, v);  chk("R11", "stall threshold reset", v, 0);
      rd(2, v);  chk("R11", "event threshold reset", v, 128);
      rd(3, v);  chk("R11", "max rate reset", v, 2);
      rd(4, v);  chk("R11", "snapshot reset", v, 0);
      rd(14, v); chk("R11", "event snapshot reset", v, 0);
      rd(15, v); chk("R11", "status reset", v, 0);
      rst_n = 1'b1;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!class_valid);
      chk("R6", "first window length after reset", n, 16);

      set_cfg(16, 0, 128, 2, 1);
      for (int p = 0; p < 12; p++) begin
         int w, st, et, rt;
         w  = 4 + (p * 5) % 13;
         st = (p % 4 == 0) ? 0 : (p * 37) % 256;
         et = (p * 53 + 20) % 256;
         rt = 1 + p % 3;
         set_cfg(w, st, et, rt, 0);
         run_window(p, w, st, et, rt);
         run_window(p + 20, w, st, et, rt);
      end
      set_cfg(300, 200, 255, 1, 0);
      run_window(99, 300, 200, 255, 1);
      set_cfg(0, 0, 0, 1, 0);
      run_window(7, 0, 0, 0, 1);
      run_window(8, 0, 0, 0, 1);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule